// File: doc/BRIEF.md
# Decimal Keypad Priority Encoder with Inverted BCD Output

This block turns nine request lines, one for each decimal digit from 1 to 9, into a four-bit BCD code. The request lines are active low. When more than one line is pulled low, the line with the larger digit number wins, and every smaller line is ignored. Digit zero has no line of its own. It is reported whenever no line is requesting.

The main code leaves the block in inverted form: a low bit means a one in the BCD value. A second output carries the same value in true polarity, formed by inverting each bit of the main code. A typical use is reading a ten-key decimal keypad or a set of digit switches, where the highest pressed key is wanted as one BCD digit.

The block is purely combinational. It has no clock, no reset and no state, so its outputs follow its inputs within the same cycle.

Top module: `dec_prio_bcd_enc`

## Requirements
- R1: Input `line_n_i` has nine bits. Bit k-1 carries the request for digit k, for k from 1 to 9. A bit at 0 means that digit is requesting, and a bit at 1 means it is idle.
- R2: With all nine lines idle (`line_n_i` = 9'h1FF), `code_n_o` is 4'b1111 and `code_o` is 4'b0000, which stands for digit zero.
- R3: When several lines request at once, the output encodes the largest requesting digit. Requests on smaller digits have no effect on either output.
- R4: Whenever line 9 requests, `code_n_o` is 4'b0110, whatever the other eight lines are doing.
- R5: When line 8 requests and line 9 is idle, `code_n_o` is 4'b0111, whatever lines 1 to 7 are doing.
- R6: When line 1 is the only requesting line, `code_n_o` is 4'b1110.
- R7: `code_o` is always the bitwise complement of `code_n_o`, so `code_o` is the BCD value of the winning digit with bit 0 as the least significant bit.
- R8: `code_o` never exceeds 9. When it is not zero, the line for digit `code_o` is requesting and every line above that digit is idle.
- R9: The outputs depend only on the present input value. Changing the inputs changes the outputs in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| line_n_i | input | 9 | Active-low requests; bit k-1 is the request for digit k |
| code_n_o | output | 4 | Inverted BCD code of the highest requesting digit (all ones when none request) |
| code_o | output | 4 | True-polarity BCD code, the bitwise inverse of `code_n_o` |

## Verification
The bench drives the encoder through every one of the 512 input words. That sweep covers every way a larger request can hide any mix of smaller ones, so it tells a correct priority order apart from a reversed order or a missing line.

Directed cases come next:
- the idle word;
- each single request;
- line 9 and line 8 with every lower line also pulled low, which separates the fixed top codes from an encoder that merges lower requests;
- walking patterns where only the lowest active line changes, which shows that lower requests are ignored.

A seeded random sequence then changes the inputs between consecutive samples. This confirms that each output follows the word present at that moment, with nothing carried over from the word before.

// File: rtl/bcd_prio_pkg.sv
package bcd_prio_pkg;

  // Default count of request lines (digits 1..DEF_LINES)
  localparam int DEF_LINES = 9;

  // Bits needed to code digits 0..n
  function automatic int code_width(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/bcd_req_normalize.sv
// Turns active-low requests into active-high ones and keeps only the
// highest active line, giving a one-hot (or all-zero) winner vector.
module bcd_req_normalize #(
  parameter int NUM_LINES = bcd_prio_pkg::DEF_LINES
) (
  input  logic [NUM_LINES-1:0] req_n_i,
  output logic [NUM_LINES-1:0] win_o
);

  logic [NUM_LINES-1:0] act;
  logic [NUM_LINES-1:0] busy_above;

  assign act = ~req_n_i;

  // busy_above[k] is set when any line above position k is active
  assign busy_above[NUM_LINES-1] = 1'b0;

  generate
    for (genvar k = 0; k < NUM_LINES - 1; k++) begin : g_chain
      assign busy_above[k] = busy_above[k+1] | act[k+1];
    end
  endgenerate

  assign win_o = act & ~busy_above;

endmodule

// File: rtl/bcd_onehot_code.sv
// Maps a one-hot winner vector to a binary digit value.
// Position k stands for digit k+1; all-zero gives digit 0.
module bcd_onehot_code #(
  parameter int NUM_LINES = bcd_prio_pkg::DEF_LINES,
  parameter int CODE_W    = bcd_prio_pkg::code_width(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] win_i,
  output logic [CODE_W-1:0]    digit_o
);

  always_comb begin
    digit_o = '0;
    for (int k = 0; k < NUM_LINES; k++) begin
      if (win_i[k]) digit_o = digit_o | CODE_W'(k + 1);
    end
  end

endmodule

// File: rtl/bcd_polarity_out.sv
// Produces the inverted main code and its true-polarity companion.
module bcd_polarity_out #(
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] digit_i,
  output logic [CODE_W-1:0] code_n_o,
  output logic [CODE_W-1:0] code_o
);

  assign code_n_o = ~digit_i;
  // True polarity is taken from the inverted code, one inverter per bit
  assign code_o   = ~code_n_o;

endmodule

// File: rtl/dec_prio_bcd_enc.sv
module dec_prio_bcd_enc #(
  parameter int NUM_LINES = bcd_prio_pkg::DEF_LINES,
  localparam int CODE_W   = bcd_prio_pkg::code_width(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] line_n_i,
  output logic [CODE_W-1:0]    code_n_o,
  output logic [CODE_W-1:0]    code_o
);

  logic [NUM_LINES-1:0] win;
  logic [CODE_W-1:0]    digit;

  // Highest active line wins; lower ones are masked (R3)
  bcd_req_normalize #(
    .NUM_LINES(NUM_LINES)
  ) u_norm (
    .req_n_i(line_n_i),
    .win_o  (win)
  );

  bcd_onehot_code #(
    .NUM_LINES(NUM_LINES),
    .CODE_W   (CODE_W)
  ) u_code (
    .win_i  (win),
    .digit_o(digit)
  );

  // Inverted main code plus true BCD (R7)
  bcd_polarity_out #(
    .CODE_W(CODE_W)
  ) u_pol (
    .digit_i (digit),
    .code_n_o(code_n_o),
    .code_o  (code_o)
  );

endmodule

// File: rtl/dec_prio_bcd_enc_chk.sv
module dec_prio_bcd_enc_chk #(
  parameter int NUM_LINES = 9,
  parameter int CODE_W    = 4
) (
  input logic [NUM_LINES-1:0] line_n_i,
  input logic [CODE_W-1:0]    code_n_o,
  input logic [CODE_W-1:0]    code_o,
  input logic [NUM_LINES-1:0] win
);

  always_comb begin
    int idx;
    idx = int'(code_o) - 1;

    p_winner_onehot_r3: assert ($onehot0(win))
      else $error("winner vector not one-hot");

    p_idle_zero_r2: assert (!(&line_n_i) || (&code_n_o))
      else $error("idle inputs did not give all-ones code");

    p_top_line_r4: assert (line_n_i[NUM_LINES-1] || (code_n_o == ~CODE_W'(NUM_LINES)))
      else $error("top line request not encoded");

    p_complement_r7: assert ((code_o ^ code_n_o) == {CODE_W{1'b1}})
      else $error("true and inverted codes disagree");

    p_range_r8: assert (int'(code_o) <= NUM_LINES)
      else $error("code out of range");

    if (idx >= 0 && idx < NUM_LINES) begin
      p_winner_low_r8: assert (line_n_i[idx] == 1'b0)
        else $error("encoded line is not requesting");
    end

    p_above_idle_r8: assert (((~line_n_i) >> code_o) == '0)
      else $error("a higher line is requesting");
  end

endmodule

bind dec_prio_bcd_enc dec_prio_bcd_enc_chk #(
  .NUM_LINES(NUM_LINES),
  .CODE_W   (CODE_W)
) u_chk (
  .line_n_i(line_n_i),
  .code_n_o(code_n_o),
  .code_o  (code_o),
  .win     (win)
);

// File: tb/dec_prio_bcd_enc_tb.sv
module dec_prio_bcd_enc_tb;

  localparam int N = 9;

  logic       clk = 1'b0;
  logic [8:0] line_n = 9'h1FF;
  logic [3:0] code_n;
  logic [3:0] code;
  int         n_checks = 0;
  int         n_fail   = 0;
  bit         done     = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  dec_prio_bcd_enc u_dut (
    .line_n_i(line_n),
    .code_n_o(code_n),
    .code_o  (code)
  );

  // Reference: search from digit 9 down to 1
  function automatic logic [3:0] ref_digit(input logic [8:0] v);
    for (int d = N; d >= 1; d--) begin
      if (v[d-1] == 1'b0) return 4'(d);
    end
    return 4'd0;
  endfunction

  task automatic check_eq(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s in=%09b actual=%04b expected=%04b", req, line_n, act, exp);
    end
  endtask

  // Drive at falling edge, sample 5 ns later (R9: no clock edge needed)
  task automatic apply(input logic [8:0] v);
    @(negedge clk);
    line_n = v;
    #5;
  endtask

  task automatic check_both(input string req, input logic [8:0] v);
    apply(v);
    check_eq(req, code_n, ~ref_digit(v));
    check_eq({req, "/R7"}, code, ref_digit(v));
  endtask

  initial begin
    logic [8:0] r;
    void'($urandom(32'd12345));

    // R2: idle state
    apply(9'h1FF);
    check_eq("R2", code_n, 4'b1111);
    check_eq("R2", code, 4'b0000);

    // R4: line 9 with every lower line also low
    apply(9'h000);
    check_eq("R4", code_n, 4'b0110);
    apply(9'h0AA);
    check_eq("R4", code_n, 4'b0110);

    // R5: line 8 with all lower lines low
    apply(9'h100);
    check_eq("R5", code_n, 4'b0111);

    // R6: only line 1
    apply(9'h1FE);
    check_eq("R6", code_n, 4'b1110);

    // R1: each single request maps to its own digit
    for (int k = 0; k < N; k++) begin
      apply(~(9'h001 << k));
      check_eq("R1", code, 4'(k + 1));
    end

    // R3: top line 7 fixed, lower lines walk; output must not move
    for (int m = 0; m < 64; m++) begin
      apply({3'b110, 6'(m)});
      check_eq("R3", code_n, 4'b1000);
    end

    // R3/R8: exhaustive sweep against the reference
    for (int v = 0; v < 512; v++) begin
      check_both("R3", 9'(v));
      check_eq("R8", 4'(code <= 4'd9), 4'd1);
    end

    // R9: random changes between samples
    for (int i = 0; i < 300; i++) begin
      r = 9'($urandom);
      check_both("R9", r);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule